// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends bytes on an asynchronous serial line. It has two stages. The host bus writes a byte into a holding register, and it can read that register back at any time. Behind the holding register sits a shift register that the host cannot reach. The shift register frames the byte and drives the serial output one bit per baud tick.

When a frame finishes and a byte is waiting, the shift register takes that byte at once and starts the next frame with no idle gap between frames. A holding-empty flag tells the host when it may write again. While the shifter sends one byte, the host can already stage the next one. With nothing waiting, the line rests high.

All line activity advances on a one-cycle `baud_tick` strobe supplied from outside. The serial output changes only on the clock edge where that strobe is high.

Top module: `ser_tx_dbuf`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1 and `rd_data` is 0.
- R2: While no byte is pending and no frame is in progress, `txd` stays 1 across any number of baud ticks.
- R3: A frame is a start bit of 0, then 8 data bits with bit 0 first, then a stop bit of 1. Each bit holds for one baud-tick period, and `txd` changes only on the edge where `baud_tick` is high.
- R4: A byte moves from the holding register into the shift register only on a baud tick, and only when the shifter is idle or has just completed its stop bit. On that same edge `hold_empty` becomes 1 and `txd` becomes 0, the start bit.
- R5: If a byte is pending when a stop bit completes, the next start bit follows on the very next tick. No idle bit is inserted.
- R6: A write (`wr_en`=1) while `hold_empty`=1 stores `wr_data` and clears `hold_empty` on the next edge. Such a write is allowed while a frame is being sent.
- R7: A write while `hold_empty`=0 is ignored: `rd_data` keeps the stored byte, and that stored byte is the one transmitted next.
- R8: A write in the same cycle that the holding byte moves to the shifter is accepted: the new byte is stored and `hold_empty` stays 0.
- R9: `rd_data` always shows the holding register's content. Reading it has no side effect, and it changes only on an accepted write.
- R10: Host writes made during a frame never change the bits of that frame. The shift register is not visible or writable from the host port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Holding register content for host readback |
| hold_empty | output | 1 | 1 when the holding register may accept a byte |
| baud_tick | input | 1 | One-cycle strobe marking a bit period boundary |
| txd | output | 1 | Serial output, idle high |

## Verification
A host write and the transfer from the holding register to the shifter can land on the same clock edge. That happens when the host writes while a byte is pending, in the cycle where a stop bit completes. The bench provokes this by raising `wr_en` together with `baud_tick` at the end of a frame. It then expects a start bit for the old byte, `hold_empty` still 0, and `rd_data` holding the new byte. The new byte must also be the one framed next. A second case writes into a full register away from any tick, and the bench checks that this write is dropped.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

   typedef enum logic {
      TX_IDLE = 1'b0,
      TX_BUSY = 1'b1
   } tx_state_e;

   // bits on the line per character: start + data + stop
   function automatic int frame_bits(input int data_w);
      return data_w + 2;
   endfunction

endpackage

// File: rtl/ser_tx_hold.sv
module ser_tx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic [DATA_W-1:0] data_q,
   output logic              empty_q
);

   logic accept;

   // a write lands when the slot is free or is being vacated this cycle
   assign accept = wr_en && (empty_q || take);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q  <= '0;
         empty_q <= 1'b1;
      end else if (accept) begin
         data_q  <= wr_data;
         empty_q <= 1'b0;
      end else if (take) begin
         empty_q <= 1'b1;
      end
   end

endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift
   import ser_tx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              pend,
   input  logic [DATA_W-1:0] pend_data,
   output logic              take,
   output logic              txd
);

   localparam int NBITS = frame_bits(DATA_W);
   localparam int CNT_W = $clog2(NBITS);

   tx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] sh;
   logic              last_bit;

   // cnt==0 while the stop bit is on the line
   assign last_bit = (cnt == '0);
   assign take     = tick && pend && ((state == TX_IDLE) || last_bit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= TX_IDLE;
         cnt   <= '0;
         sh    <= '1;
         txd   <= 1'b1;
      end else if (tick) begin
         if (take) begin
            sh    <= pend_data;
            txd   <= 1'b0;
            cnt   <= CNT_W'(NBITS - 1);
            state <= TX_BUSY;
         end else if (state == TX_BUSY) begin
            if (last_bit) begin
               state <= TX_IDLE;
               txd   <= 1'b1;
            end else begin
               txd <= sh[0];
               sh  <= {1'b1, sh[DATA_W-1:1]};
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/ser_tx_dbuf.sv
module ser_tx_dbuf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              hold_empty,
   input  logic              baud_tick,
   output logic              txd
);

   generate
      if (DATA_W < 5 || DATA_W > 16) begin : g_bad_width
         $error("ser_tx_dbuf: DATA_W must lie in 5..16");
      end
   endgenerate

   logic load_pulse;

   ser_tx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .take    (load_pulse),
      .data_q  (rd_data),
      .empty_q (hold_empty)
   );

   ser_tx_shift #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (baud_tick),
      .pend      (!hold_empty),
      .pend_data (rd_data),
      .take      (load_pulse),
      .txd       (txd)
   );

endmodule

// File: rtl/ser_tx_dbuf_chk.sv
module ser_tx_dbuf_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              hold_empty,
   input logic              baud_tick,
   input logic              txd,
   input logic              load_pulse
);

   assert_txd_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !baud_tick |=> $stable(txd));

   assert_load_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load_pulse |-> (baud_tick && !hold_empty));

   assert_load_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load_pulse |=> !txd);

   assert_load_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (load_pulse && !wr_en) |=> hold_empty);

   assert_empty_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_empty && wr_en) |=> (!hold_empty && rd_data == $past(wr_data)));

   assert_full_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_empty && wr_en && !load_pulse) |=> ($stable(rd_data) && !hold_empty));

   assert_load_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (load_pulse && wr_en) |=> (!hold_empty && rd_data == $past(wr_data)));

   assert_readback_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(rd_data));

endmodule

bind ser_tx_dbuf ser_tx_dbuf_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_ser_tx_dbuf.sv
`timescale 1ns/1ps
module sim_ser_tx_dbuf;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       baud_tick = 1'b0;
   logic [7:0] rd_data;
   logic       hold_empty;
   logic       txd;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   ser_tx_dbuf u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .hold_empty(hold_empty),
      .baud_tick(baud_tick), .txd(txd)
   );

   // vector: data byte, expected line bits (bit 0 sent first)
   localparam int NV = 6;
   localparam logic [17:0] VEC [NV] = '{
      {8'h55, 1'b1, 8'h55, 1'b0},
      {8'hA3, 1'b1, 8'hA3, 1'b0},
      {8'h00, 1'b1, 8'h00, 1'b0},
      {8'hFF, 1'b1, 8'hFF, 1'b0},
      {8'h01, 1'b1, 8'h01, 1'b0},
      {8'h80, 1'b1, 8'h80, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // one tick, optional write in the same cycle; sample after the edge
   task automatic do_tick(input logic w, input logic [7:0] d);
      @(negedge clk);
      baud_tick = 1'b1; wr_en = w; wr_data = d;
      @(negedge clk);
      baud_tick = 1'b0; wr_en = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // after the start bit: data bits then stop bit
   task automatic frame_tail(input logic [7:0] d, input string tag);
      logic [9:0] fr;
      fr = {1'b1, d, 1'b0};
      for (int k = 1; k < 10; k++) begin
         do_tick(1'b0, 8'h00);
         chk($sformatf("%s bit%0d", tag, k), {31'b0, txd}, {31'b0, fr[k]});
      end
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 txd", {31'b0, txd}, 32'd1);
      chk("R1 hold_empty", {31'b0, hold_empty}, 32'd1);
      chk("R1 rd_data", {24'b0, rd_data}, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < 3; i++) begin
         do_tick(1'b0, 8'h00);
         chk("R2 idle high", {31'b0, txd}, 32'd1);
      end

      // table walk: one isolated frame per vector
      for (int v = 0; v < NV; v++) begin
         logic [7:0] d;
         logic [9:0] fr;
         d  = VEC[v][17:10];
         fr = VEC[v][9:0];
         do_write(d);
         chk("R6 write clears empty", {31'b0, hold_empty}, 32'd0);
         chk("R9 readback", {24'b0, rd_data}, {24'b0, d});
         do_tick(1'b0, 8'h00);
         chk("R4 start bit", {31'b0, txd}, {31'b0, fr[0]});
         chk("R4 empty on load", {31'b0, hold_empty}, 32'd1);
         for (int k = 1; k < 10; k++) begin
            do_tick(1'b0, 8'h00);
            chk($sformatf("R3 vec%0d bit%0d", v, k), {31'b0, txd}, {31'b0, fr[k]});
         end
         do_tick(1'b0, 8'h00);
         chk("R2 idle after frame", {31'b0, txd}, 32'd1);
      end

      // staged write during a frame, full-register write dropped, chaining
      do_write(8'h3C);
      do_tick(1'b0, 8'h00);
      chk("R4 start A", {31'b0, txd}, 32'd0);
      do_write(8'hC5);
      chk("R6 write during frame", {31'b0, hold_empty}, 32'd0);
      chk("R6 staged byte", {24'b0, rd_data}, 32'hC5);
      do_write(8'h99);
      chk("R7 full write ignored", {24'b0, rd_data}, 32'hC5);
      frame_tail(8'h3C, "R10 frame A intact");
      do_tick(1'b0, 8'h00);
      chk("R5 back-to-back start B", {31'b0, txd}, 32'd0);
      chk("R4 empty after chain", {31'b0, hold_empty}, 32'd1);
      do_write(8'h6A);
      frame_tail(8'hC5, "R7 stored byte sent");
      // write in the same cycle as the load
      do_tick(1'b1, 8'h17);
      chk("R8 start D", {31'b0, txd}, 32'd0);
      chk("R8 still full", {31'b0, hold_empty}, 32'd0);
      chk("R8 new byte stored", {24'b0, rd_data}, 32'h17);
      frame_tail(8'h6A, "R10 frame D intact");
      do_tick(1'b0, 8'h00);
      chk("R5 start E", {31'b0, txd}, 32'd0);
      frame_tail(8'h17, "R8 byte E sent");
      do_tick(1'b0, 8'h00);
      chk("R2 idle at end", {31'b0, txd}, 32'd1);
      chk("R9 readback unchanged", {24'b0, rd_data}, 32'h17);
      chk("R4 empty at end", {31'b0, hold_empty}, 32'd1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule